// File: doc/BRIEF.md
# Full-Duplex SPI Master with Byte FIFOs

This block is a memory-mapped SPI master that moves 8-bit words in both directions at once. Software places outgoing bytes in a 16-entry transmit FIFO and takes incoming bytes from a 16-entry receive FIFO. Both go through one data register: a write pushes and a read pops. A transfer is launched by a single write to the status register. That write carries a start bit and two byte counts. The first count says how many bytes come from the transmit FIFO. The second says how many bytes are clocked in total. Once the transmit count is used up, zero bytes are sent while reception continues.

The configuration register sets the following:
- the SCK idle level;
- the clock phase;
- bit order;
- the chip-select active level;
- an enable for the engine;
- a 16-bit clock divider;
- three interrupt enables.

The engine waits at byte boundaries while it needs a transmit byte that is not there, or while the receive FIFO has no room. Software can therefore service a transfer longer than the FIFOs. A sticky finish flag and a level interrupt report the end of a transfer.

Register addresses on the 2-bit bus address are: 0 data FIFO, 1 status/control, 2 configuration, 3 interrupt. Reads are combinational from the address. A read strobe only matters for the data address, where it pops.

Top module: `spi_duplex_master`

## Requirements
- R1: The transmit FIFO holds 16 bytes. A data write when it is full is ignored. The status register shows the transmit count modulo 16 in bits 11:8, transmit-empty in bit 2 and transmit-full in bit 3. After reset the status register reads 0x14.
- R2: The receive FIFO holds 16 bytes. The status register shows the receive count modulo 16 in bits 15:12, receive-empty in bit 4 and receive-full in bit 5. A data read when the FIFO is empty returns 0 and pops nothing.
- R3: A status write with bit 0 set starts a transfer, with the transmit count taken from bits 23:16 and the total count from bits 31:24. The start takes effect only when the engine is idle and configuration bit 6 is 1. Both counts read back in the same status bit positions, and status bit 0 reads 1 while a transfer runs.
- R4: Byte k of a transfer sends the next transmit FIFO entry if k is below the transmit count, and 0x00 otherwise. Every byte clocked in is pushed to the receive FIFO. A byte does not start while its transmit byte is missing or the receive FIFO lacks room.
- R5: Configuration bit 0 is the SCK idle level, which SCK holds whenever no transfer runs. With bit 1 clear, MISO is sampled on the leading edge of each bit. With bit 1 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Bit 2 is stored only.
- R6: Configuration bit 4 set sends and receives each byte LSB first; clear means MSB first.
- R7: With N in configuration bits 31:16, each SCK half-period lasts N+1 clock cycles.
- R8: Chip select is active high when configuration bit 5 is set, otherwise active low. It goes inactive one half-period after the last SCK edge. The first SCK edge comes one half-period after chip select goes active when bit 1 is set, and two half-periods after when bit 1 is clear.
- R9: Status bit 6 is set when chip select is released at the end of a transfer. It stays set until a status write with bit 6 set.
- R10: A status write with bit 1 set aborts any transfer, empties both FIFOs and clears the finish flag, in the following cycle.
- R11: A pending interrupt bit is set by any of these conditions, each gated by its configuration enable:
  - the end of a transfer (enable bit 15);
  - an empty transmit FIFO while busy (enable bit 11);
  - a full receive FIFO (enable bit 14).

  The irq output is that bit, which reads back at bit 6 of address 3. Writing 1 to bit 6 of address 3 clears it unless a set condition holds in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |
| sck | output | 1 | SPI serial clock |
| cs_out | output | 1 | Chip select, polarity set by configuration |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker watches the following on every cycle:
- SCK rests at its idle level whenever the engine is idle;
- a transfer starts only from a start write;
- the transmit count never passes the FIFO depth, and a full FIFO ignores pushes;
- empty reads return zero;
- the finish flag accompanies every normal end;
- a soft reset empties the FIFOs;
- the interrupt holds until it is cleared.

Only the bench scenarios can show the serial behaviour:
- the bit order and edge choice on the wire;
- the half-period length and the chip-select lead and lag;
- zero fill after the transmit count;
- stalling and refilling during a transfer longer than the FIFOs.

The bench sweeps every combination of idle level, phase and bit order with MISO looped back to MOSI.

// File: rtl/spi_duplex_master.sv
`timescale 1ns/1ps
module spi_duplex_master #(
  parameter int FIFO_AW = 4,
  parameter int DIV_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sck,
  output logic        cs_out,
  output logic        mosi,
  input  logic        miso
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int CW    = FIFO_AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_WAIT, S_BYTE, S_TRAIL} st_t;
  st_t st;

  logic [31:0] cfg;
  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [FIFO_AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]  h;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]  byte_cnt, tx_len, tot_len, txsh, rxsh;
  logic        fin, pend;

  wire wr_data = bus_wr && bus_addr == 2'd0;
  wire rd_data = bus_rd && bus_addr == 2'd0;
  wire wr_stat = bus_wr && bus_addr == 2'd1;
  wire wr_cfg  = bus_wr && bus_addr == 2'd2;
  wire wr_int  = bus_wr && bus_addr == 2'd3;

  wire cpol = cfg[0];
  wire cpha = cfg[1];
  wire lsb  = cfg[4];
  wire [DIV_W-1:0] div_n = cfg[16 +: DIV_W];

  wire busy     = st != S_IDLE;
  wire tx_empty = tx_cnt == 0;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == 0;
  wire rx_full  = rx_cnt == CW'(DEPTH);

  wire srst = wr_stat && bus_wdata[1];
  wire go   = wr_stat && bus_wdata[0] && !srst && !busy && cfg[6];
  wire tick = (st == S_LEAD || st == S_BYTE || st == S_TRAIL) && div_cnt == div_n;
  wire last_half = st == S_BYTE && tick && h == 4'hF;

  wire need_tx  = byte_cnt < tx_len;
  wire more     = byte_cnt != tot_len;
  wire rx_push  = last_half;
  wire rx_ok    = (rx_cnt + CW'(rx_push)) < CW'(DEPTH);
  wire can_go   = more && (!need_tx || !tx_empty) && rx_ok;
  wire at_bound = (st == S_LEAD && tick) || st == S_WAIT || last_half;
  wire launch   = at_bound && can_go;
  wire tx_pop   = launch && need_tx;
  wire tx_push  = wr_data && !tx_full;
  wire rx_pop   = rd_data && !rx_empty;
  wire fin_evt  = (st == S_TRAIL && tick) || (last_half && !more && cpha);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; h <= '0; byte_cnt <= '0; tx_len <= '0; tot_len <= '0;
      txsh <= '0; rxsh <= '0; div_cnt <= '0;
    end else if (srst) begin
      st <= S_IDLE; h <= '0; byte_cnt <= '0; div_cnt <= '0;
    end else begin
      div_cnt <= (tick || st == S_IDLE || st == S_WAIT) ? '0 : div_cnt + 1'b1;
      case (st)
        S_IDLE:  if (go) begin
                   st <= S_LEAD; byte_cnt <= '0;
                   tx_len <= bus_wdata[23:16]; tot_len <= bus_wdata[31:24];
                 end
        S_LEAD:  if (tick) st <= launch ? S_BYTE : (more ? S_WAIT : S_TRAIL);
        S_WAIT:  if (launch) st <= S_BYTE;
        S_BYTE:  if (tick) begin
                   if (h != 4'hF) h <= h + 1'b1;
                   else st <= launch ? S_BYTE : more ? S_WAIT : (cpha ? S_IDLE : S_TRAIL);
                 end
        default: if (tick) st <= S_IDLE;
      endcase
      if (launch) begin
        h <= '0;
        byte_cnt <= byte_cnt + 1'b1;
        txsh <= need_tx ? tx_mem[tx_rp] : 8'h00;
      end
      if (st == S_BYTE && tick && !h[0])
        rxsh <= lsb ? {miso, rxsh[7:1]} : {rxsh[6:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; fin <= 1'b0; pend <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= bus_wdata;
      if (srst) fin <= 1'b0;
      else if (fin_evt) fin <= 1'b1;
      else if (wr_stat && bus_wdata[6]) fin <= 1'b0;
      if ((cfg[15] && fin_evt) || (cfg[11] && tx_empty && busy) || (cfg[14] && rx_full))
        pend <= 1'b1;
      else if (wr_int && bus_wdata[6]) pend <= 1'b0;
    end
  end

  wire [2:0] bit_i = h[3:1];
  assign sck    = (st == S_BYTE) ? (cpol ^ (cpha ? ~h[0] : h[0])) : cpol;
  assign mosi   = (st == S_BYTE) ? txsh[lsb ? bit_i : 3'd7 - bit_i] : 1'b0;
  assign cs_out = cfg[5] ? busy : !busy;
  assign irq    = pend;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {24'h0, rx_empty ? 8'h00 : rx_mem[rx_rp]};
      2'd1:    bus_rdata = {tot_len, tx_len, rx_cnt[3:0], tx_cnt[3:0], 1'b0, fin,
                            rx_full, rx_empty, tx_full, tx_empty, 1'b0, busy};
      2'd2:    bus_rdata = cfg;
      default: bus_rdata = {25'h0, pend, 5'h0, busy};
    endcase
  end
endmodule

// File: rtl/spi_duplex_master_chk.sv
`timescale 1ns/1ps
module spi_duplex_master_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          irq,
  input logic          sck,
  input logic          busy,
  input logic          fin,
  input logic [31:0]   cfg,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  wire start_wr = bus_wr && bus_addr == 2'd1 && bus_wdata[0];
  wire srst_wr  = bus_wr && bus_addr == 2'd1 && bus_wdata[1];
  wire clr_wr   = bus_wr && bus_addr == 2'd3 && bus_wdata[6];

  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cfg[0]); // R5
  AST_START_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH)); // R1
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && bus_wr && bus_addr == 2'd0 && !busy) |=> tx_cnt == CW'(DEPTH)); // R1
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && rx_cnt == 0) |-> bus_rdata == 32'h0); // R2
  AST_FINISH_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(srst_wr)) |-> fin); // R9
  AST_SOFT_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (tx_cnt == 0 && rx_cnt == 0 && !busy && !fin)); // R10
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R11
endmodule

bind spi_duplex_master spi_duplex_master_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck), .busy(busy),
  .fin(fin), .cfg(cfg), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_duplex_master.sv
`timescale 1ns/1ps
module test_spi_duplex_master;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, sck, cs_out, mosi, miso;

  assign miso = mosi;

  spi_duplex_master i_spi_duplex_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck(sck),
    .cs_out(cs_out), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic cpol_b = 0, cpha_b = 0, lsb_b = 0, csh_b = 0;
  int   n_b = 0;
  logic [7:0] txd [256];
  logic [7:0] rxd [256];
  logic [7:0] mon_bytes [256];
  logic [7:0] mon_sh;
  int  mon_bits, edges;
  time cs_on_t, cs_off_t, first_t, last_t, prev_t, min_iv;

  wire cs_act = (cs_out === csh_b);

  always @(cs_out) begin
    if (cs_act) cs_on_t = $time; else cs_off_t = $time;
  end

  always @(sck) begin
    if (cs_act && $time > 0) begin
      edges++;
      if (edges == 1) first_t = $time;
      else if ($time - prev_t < min_iv) min_iv = $time - prev_t;
      prev_t = $time;
      last_t = $time;
      if ((sck !== cpol_b) ^ cpha_b) begin
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits % 8 == 0) mon_bytes[mon_bits/8 - 1] = mon_sh;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIFO-SPI FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    bus_addr = 0; bus_rd = 1; #1 d = bus_rdata[7:0];
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic set_cfg(input bit cp, input bit ph, input bit ls, input bit ch,
                         input int n, input bit en, input logic [15:0] ints);
    cpol_b = cp; cpha_b = ph; lsb_b = ls; csh_b = ch; n_b = n;
    wr(2, {n[15:0], 16'h0} | ints | {25'h0, en, ch, ls, 1'b0, ~ph, ph, cp});
  endtask

  task automatic mon_clear;
    edges = 0; mon_bits = 0; mon_sh = 0; min_iv = 64'd1000000;
    cs_on_t = 0; cs_off_t = 0; first_t = 0; last_t = 0;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic run_xfer(input int txl, input int tot, input int pre);
    int pushed, got;
    logic [31:0] s;
    logic [7:0] d, e;
    time half;
    half = (n_b + 1) * 10;
    mon_clear();
    pushed = pre;
    while (pushed < txl && pushed < 16) begin wr(0, {24'h0, txd[pushed]}); pushed++; end
    wr(1, {tot[7:0], txl[7:0], 16'h0001});
    got = 0;
    forever begin
      peek(1, s);
      if (s[15:12] != 0 || s[5]) begin pop(d); rxd[got] = d; got++; end
      else if (pushed < txl && !s[3]) begin wr(0, {24'h0, txd[pushed]}); pushed++; end
      else if (!s[0] && got == tot) break;
    end
    for (int k = 0; k < tot; k++) begin
      e = (k < txl) ? txd[k] : 8'h00;
      check(rxd[k] == e, "R4 rx byte", rxd[k], e);
      check(mon_bytes[k] == (lsb_b ? rev8(e) : e), "R6 wire byte", mon_bytes[k], lsb_b ? rev8(e) : e);
    end
    check(edges == 16 * tot, "R5 edge count", edges, 16 * tot);
    check(min_iv == half, "R7 half period", min_iv, half);
    check(first_t - cs_on_t == (cpha_b ? half : 2 * half), "R8 cs lead", first_t - cs_on_t, cpha_b ? half : 2 * half);
    check(cs_off_t - last_t == half, "R8 cs lag", cs_off_t - last_t, half);
    peek(1, s);
    check(s[31:16] == {tot[7:0], txl[7:0]}, "R3 length echo", s[31:16], {tot[7:0], txl[7:0]});
    check(s[6] == 1'b1, "R9 finish set", s[6], 1);
    check(sck == cpol_b && cs_out == !csh_b, "R5 idle levels", {sck, cs_out}, {cpol_b, !csh_b});
    wr(1, 32'h40);
    peek(1, s);
    check(s[6] == 1'b0, "R9 finish cleared", s[6], 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FIFO-SPI FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [7:0] d;
    mon_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    peek(1, s); check(s == 32'h14, "R1 reset status", s, 32'h14);
    peek(2, s); check(s == 0, "R5 reset config", s, 0);
    check(irq == 0 && sck == 0 && cs_out == 1, "R8 reset pins", {irq, sck, cs_out}, 3'b001);

    for (int k = 0; k < 16; k++) txd[k] = 8'(k * 17 + 9);
    for (int k = 0; k < 16; k++) wr(0, {24'h0, txd[k]});
    wr(0, 32'hEE);
    peek(1, s); check(s == 32'h18, "R1 full status", s, 32'h18);
    pop(d); check(d == 0, "R2 empty read", d, 0);
    peek(1, s); check(s[15:12] == 0 && s[4], "R2 empty unchanged", s, 32'h18);
    set_cfg(0, 0, 0, 0, 0, 1, 16'h0);
    run_xfer(16, 17, 16);

    set_cfg(0, 0, 0, 0, 0, 0, 16'h0);
    mon_clear();
    wr(1, 32'h0303_0001);
    repeat (4) @(posedge clk);
    peek(1, s); check(s[0] == 0 && edges == 0, "R3 start needs enable", s[0], 0);

    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int ls = 0; ls < 2; ls++)
          for (int ni = 0; ni < 2; ni++)
            for (int li = 0; li < 2; li++) begin
              set_cfg(cp[0], ph[0], ls[0], cp[0] ^ ls[0], ni * 2, 1, 16'h0);
              for (int k = 0; k < 4; k++) txd[k] = 8'(cp * 97 + ph * 53 + ls * 31 + ni * 11 + li * 7 + k * 71 + 3);
              run_xfer(li ? 1 : 2, li ? 3 : 2, 0);
            end

    set_cfg(1, 1, 0, 1, 0, 1, 16'h0);
    for (int k = 0; k < 24; k++) txd[k] = 8'(k * 45 + 1);
    run_xfer(20, 24, 0);

    set_cfg(0, 1, 1, 0, 1, 1, 16'h8000);
    txd[0] = 8'hA5;
    check(irq == 0, "R11 idle no irq", irq, 0);
    run_xfer(1, 1, 0);
    peek(3, s); check(irq == 1 && s[6], "R11 finish irq", {irq, s[6]}, 2'b11);
    wr(3, 32'h40);
    peek(3, s); check(irq == 0 && !s[6], "R11 irq cleared", {irq, s[6]}, 0);

    set_cfg(0, 0, 0, 0, 0, 1, 16'h0800);
    wr(1, 32'h0100_0001);
    repeat (3) @(posedge clk);
    #1 check(irq == 1, "R11 tx empty irq", irq, 1);
    repeat (40) @(posedge clk);
    pop(d);
    wr(1, 32'h40);
    wr(3, 32'h40);
    #1 check(irq == 0, "R11 clear after idle", irq, 0);

    set_cfg(1, 0, 0, 1, 3, 1, 16'h0);
    for (int k = 0; k < 3; k++) wr(0, 32'h5A);
    wr(1, 32'h0303_0001);
    repeat (20) @(posedge clk);
    peek(1, s); check(s[0] == 1, "R10 busy before reset", s[0], 1);
    wr(1, 32'h2);
    peek(1, s); check(s[15:0] == 16'h0014, "R10 flushed", s[15:0], 16'h0014);
    check(cs_out == 0 && sck == 1, "R10 pins idle", {cs_out, sck}, 2'b01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule